// File: doc/BRIEF.md
# Banked Register File with Mode-Selected Stack Pointers

This block is the general-purpose register storage of a 16-bit processor. It holds two banks of six working registers, one stack pointer for each of three privilege modes, and a single program counter. That makes fifteen stored words plus the PC. The instruction datapath sees only eight register numbers, 0 to 7. Two fields of the processor status word decide which physical register a number reaches. Bit 11 picks the working bank for numbers 0 to 5. Bits 15:14 pick the current mode, and with it the stack pointer that number 6 reaches. Number 7 always reaches the program counter.

The block has two combinational read ports and one clocked write port, all addressed by register number. It also has a side port that lets privileged logic write the stack pointer of any mode, independent of the current mode. The program counter has its own controls: one adds 2, the other loads a new value. They sit beside the general write port, so sequencing logic can advance or redirect fetch without spending the write port.

Top module: `banked_gpr_file`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, every register number reads 0 on both ports for every status word value.
- R2: Register numbers 0 to 5 reach bank 0 when status bit 11 is 0 and bank 1 when it is 1. The two banks hold separate values.
- R3: Register number 6 reaches the stack pointer selected by status bits 15:14: 00 kernel, 01 supervisor, 11 user. The reserved code 10 reaches the kernel stack pointer.
- R4: Register number 7 reaches one program counter, whatever the bank and mode fields hold.
- R5: The two read ports decode their register numbers independently and show data in the same cycle as their address.
- R6: A read of a register that is being written in the same cycle returns the old value. The new value appears after the clock edge.
- R7: When `sp_wr_en_i` is high, `sp_wr_data_i` is written to the stack pointer of `sp_wr_mode_i`, using the same 00/01/11/10 coding as R3, whatever the current mode.
- R8: When the write port and the side port target the same stack pointer in one cycle, the write port's data is stored.
- R9: `pc_inc_i` adds 2 to the program counter, wrapping modulo 2^16.
- R10: `pc_load_i` loads `pc_load_data_i` into the program counter and takes priority over the increment.
- R11: A write-port write to register number 7 sets the program counter and takes priority over both load and increment.
- R12: With `wr_en_i` and `sp_wr_en_i` low, no stored working register or stack pointer changes, whatever is on the write data and address inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psw_i | input | 16 | Processor status word; bit 11 selects the bank, bits 15:14 the mode |
| rd_a_sel_i | input | 3 | Register number for read port A |
| rd_a_data_o | output | 16 | Read port A data |
| rd_b_sel_i | input | 3 | Register number for read port B |
| rd_b_data_o | output | 16 | Read port B data |
| wr_en_i | input | 1 | Write port enable |
| wr_sel_i | input | 3 | Write port register number |
| wr_data_i | input | 16 | Write port data |
| sp_wr_en_i | input | 1 | Enable for the explicit-mode stack pointer write |
| sp_wr_mode_i | input | 2 | Mode whose stack pointer the side port writes |
| sp_wr_data_i | input | 16 | Side port data |
| pc_inc_i | input | 1 | Advance the program counter by 2 |
| pc_load_i | input | 1 | Load the program counter |
| pc_load_data_i | input | 16 | Program counter load value |

## Verification
The risky overlap is a stack pointer or PC update that lands in the same cycle as another source aimed at the same word. Examples are a write-port store to register 6 while the side port writes the same mode's pointer, or a write to register 7 alongside a load and an increment. Directed cycles drive all the contending controls together, and random cycles do so by chance. A model in the bench resolves each case by the stated priorities, and reads in the following cycle judge which value was kept. Reads in the contended cycle itself must still return the old value.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_SUPER  = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_USER   = 2'b11
  } cpu_mode_e;

  localparam int unsigned SP_SLOTS = 3;

  // Slot of a mode's stack pointer inside the stack pointer group.
  function automatic logic [1:0] sp_slot(input logic [1:0] mode);
    case (cpu_mode_e'(mode))
      MODE_SUPER: sp_slot = 2'd1;
      MODE_USER:  sp_slot = 2'd2;
      default:    sp_slot = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/gpr_rst_sync.sv
module gpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/gpr_addr_map.sv
module gpr_addr_map
  import gpr_pkg::*;
#(
  parameter int unsigned WORK_REGS = 6,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             bank_i,
  input  logic [1:0]       mode_i,
  output logic [IDX_W-1:0] idx_o
);

  localparam int unsigned SP_BASE = 2 * WORK_REGS;
  localparam int unsigned PC_IDX  = SP_BASE + SP_SLOTS;

  always_comb begin
    if (int'(sel_i) < WORK_REGS) begin
      idx_o = bank_i ? IDX_W'(WORK_REGS + int'(sel_i)) : IDX_W'(sel_i);
    end else if (int'(sel_i) == WORK_REGS) begin
      idx_o = IDX_W'(SP_BASE + int'(sp_slot(mode_i)));
    end else begin
      idx_o = IDX_W'(PC_IDX);
    end
  end

endmodule

// File: rtl/gpr_pc_unit.sv
module gpr_pc_unit #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_wr_i,
  input  logic [DATA_W-1:0] port_data_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              inc_i,
  output logic [DATA_W-1:0] pc_o
);

  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] pc_d;
  logic              pc_en;

  always_comb begin
    pc_en = port_wr_i | load_i | inc_i;
    if (port_wr_i)   pc_d = port_data_i;
    else if (load_i) pc_d = load_data_i;
    else             pc_d = pc_q + DATA_W'(PC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && !port_wr_i) |=> (pc_o == $past(pc_o) + DATA_W'(PC_STEP)));

  // R10
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !port_wr_i) |=> (pc_o == $past(load_data_i)));

  // R11
  pc_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr_i |=> (pc_o == $past(port_data_i)));

endmodule

// File: rtl/banked_gpr_file.sv
module banked_gpr_file
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PSW_W     = 16,
  parameter int unsigned WORK_REGS = 6,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BANK_BIT  = 11,
  parameter int unsigned MODE_LSB  = 14,
  parameter int unsigned PC_STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PSW_W-1:0]  psw_i,
  input  logic [SEL_W-1:0]  rd_a_sel_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [SEL_W-1:0]  rd_b_sel_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sp_wr_en_i,
  input  logic [1:0]        sp_wr_mode_i,
  input  logic [DATA_W-1:0] sp_wr_data_i,
  input  logic              pc_inc_i,
  input  logic              pc_load_i,
  input  logic [DATA_W-1:0] pc_load_data_i
);

  localparam int unsigned SP_BASE = 2 * WORK_REGS;
  localparam int unsigned PC_IDX  = SP_BASE + SP_SLOTS;
  localparam int unsigned NPHYS   = PC_IDX + 1;
  localparam int unsigned IDX_W   = $clog2(NPHYS);
  localparam int unsigned SP_SEL  = WORK_REGS;
  localparam int unsigned PC_SEL  = WORK_REGS + 1;

  logic              rst_s_n;
  logic              bank;
  logic [1:0]        mode;
  logic [IDX_W-1:0]  rd_a_idx;
  logic [IDX_W-1:0]  rd_b_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  sp_idx;
  logic              pc_port_wr;
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] regs_w [NPHYS];

  gpr_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign bank = psw_i[BANK_BIT];
  assign mode = psw_i[MODE_LSB +: 2];

  gpr_addr_map #(.WORK_REGS(WORK_REGS), .SEL_W(SEL_W), .IDX_W(IDX_W)) i_map_rd_a (
    .sel_i (rd_a_sel_i), .bank_i (bank), .mode_i (mode), .idx_o (rd_a_idx)
  );

  gpr_addr_map #(.WORK_REGS(WORK_REGS), .SEL_W(SEL_W), .IDX_W(IDX_W)) i_map_rd_b (
    .sel_i (rd_b_sel_i), .bank_i (bank), .mode_i (mode), .idx_o (rd_b_idx)
  );

  gpr_addr_map #(.WORK_REGS(WORK_REGS), .SEL_W(SEL_W), .IDX_W(IDX_W)) i_map_wr (
    .sel_i (wr_sel_i), .bank_i (bank), .mode_i (mode), .idx_o (wr_idx)
  );

  always_comb begin
    sp_idx     = IDX_W'(SP_BASE + int'(sp_slot(sp_wr_mode_i)));
    pc_port_wr = wr_en_i && (wr_idx == IDX_W'(PC_IDX));
  end

  gpr_pc_unit #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) i_pc_unit (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .port_wr_i   (pc_port_wr),
    .port_data_i (wr_data_i),
    .load_i      (pc_load_i),
    .load_data_i (pc_load_data_i),
    .inc_i       (pc_inc_i),
    .pc_o        (pc_q)
  );

  // Stored words: working banks, then the stack pointer group.
  for (genvar g = 0; g < PC_IDX; g++) begin : g_reg
    logic              hit_main;
    logic              hit_sp;
    logic              en;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;

    always_comb begin
      hit_main = wr_en_i && (wr_idx == IDX_W'(g));
      hit_sp   = sp_wr_en_i && (sp_idx == IDX_W'(g));
      en       = hit_main | hit_sp;
      d        = hit_main ? wr_data_i : sp_wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) q <= '0;
      else if (en)  q <= d;
    end

    assign regs_w[g] = q;
  end

  assign regs_w[PC_IDX] = pc_q;

  assign rd_a_data_o = regs_w[rd_a_idx];
  assign rd_b_data_o = regs_w[rd_b_idx];

  // R7
  sp_side_wr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sp_wr_en_i && !(wr_en_i && (wr_idx == sp_idx)))
      |=> (regs_w[$past(sp_idx)] == $past(sp_wr_data_i)));

  // R8
  sp_collide_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sp_wr_en_i && wr_en_i && (wr_idx == sp_idx))
      |=> (regs_w[$past(sp_idx)] == $past(wr_data_i)));

  // R4
  pc_view_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_a_sel_i == SEL_W'(PC_SEL)) |-> (rd_a_data_o == pc_q));

  // R3
  rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((mode == MODE_RSVD) && (rd_b_sel_i == SEL_W'(SP_SEL)))
      |-> (rd_b_data_o == regs_w[SP_BASE]));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!wr_en_i && !sp_wr_en_i && (rd_a_sel_i != SEL_W'(PC_SEL)))
      |=> ($stable(psw_i) && $stable(rd_a_sel_i)) -> $stable(rd_a_data_o));

endmodule

// File: tb/test_banked_gpr_file.sv
`timescale 1ns/1ps
module test_banked_gpr_file;

  logic        clk;
  logic        rst_n;
  logic [15:0] psw_i;
  logic [2:0]  rd_a_sel_i, rd_b_sel_i, wr_sel_i;
  logic [15:0] rd_a_data_o, rd_b_data_o, wr_data_i;
  logic        wr_en_i, sp_wr_en_i, pc_inc_i, pc_load_i;
  logic [1:0]  sp_wr_mode_i;
  logic [15:0] sp_wr_data_i, pc_load_data_i;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] m [16];

  banked_gpr_file i_banked_gpr_file (
    .clk (clk), .rst_n (rst_n), .psw_i (psw_i),
    .rd_a_sel_i (rd_a_sel_i), .rd_a_data_o (rd_a_data_o),
    .rd_b_sel_i (rd_b_sel_i), .rd_b_data_o (rd_b_data_o),
    .wr_en_i (wr_en_i), .wr_sel_i (wr_sel_i), .wr_data_i (wr_data_i),
    .sp_wr_en_i (sp_wr_en_i), .sp_wr_mode_i (sp_wr_mode_i), .sp_wr_data_i (sp_wr_data_i),
    .pc_inc_i (pc_inc_i), .pc_load_i (pc_load_i), .pc_load_data_i (pc_load_data_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Mode code to stack pointer slot: 00 kernel, 01 supervisor, 11 user, 10 kernel.
  function automatic int slot(input logic [1:0] md);
    if (md == 2'b01) return 1;
    if (md == 2'b11) return 2;
    return 0;
  endfunction

  // Model numbering: 0-5 bank 0, 6-11 bank 1, 12-14 stack pointers, 15 PC.
  function automatic int phys(input logic [2:0] sel, input logic [15:0] psw);
    if (sel < 3'd6) return psw[11] ? 6 + int'(sel) : int'(sel);
    if (sel == 3'd6) return 12 + slot(psw[15:14]);
    return 15;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string auto_tag(input logic [2:0] sel, input int p, input logic we, input int wp,
                                     input logic spe, input int sidx, input logic inc, input logic ld);
    if ((we && wp == p) || (spe && sidx == p) || (p == 15 && (inc || ld))) return "R6";
    if (sel < 3'd6) return "R2";
    if (sel == 3'd6) return "R3";
    return "R4";
  endfunction

  task automatic op(input logic [15:0] psw, input logic [2:0] ra, input logic [2:0] rb,
                    input logic we, input logic [2:0] ws, input logic [15:0] wd,
                    input logic spe, input logic [1:0] spm, input logic [15:0] spd,
                    input logic inc, input logic ld, input logic [15:0] ldd, input string tag);
    int wp, sidx, pa, pb;
    psw_i = psw; rd_a_sel_i = ra; rd_b_sel_i = rb;
    wr_en_i = we; wr_sel_i = ws; wr_data_i = wd;
    sp_wr_en_i = spe; sp_wr_mode_i = spm; sp_wr_data_i = spd;
    pc_inc_i = inc; pc_load_i = ld; pc_load_data_i = ldd;
    #1;
    wp = phys(ws, psw); sidx = 12 + slot(spm);
    pa = phys(ra, psw); pb = phys(rb, psw);
    chk((tag != "") ? tag : auto_tag(ra, pa, we, wp, spe, sidx, inc, ld), "port a", rd_a_data_o, m[pa]);
    chk((tag != "") ? tag : auto_tag(rb, pb, we, wp, spe, sidx, inc, ld), "port b", rd_b_data_o, m[pb]);
    @(posedge clk);
    if (we && wp == 15) m[15] = wd;
    else if (ld)        m[15] = ldd;
    else if (inc)       m[15] = m[15] + 16'd2;
    if (spe && !(we && wp == sidx)) m[sidx] = spd;
    if (we && wp != 15) m[wp] = wd;
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] psw, input logic [2:0] ra, input logic [2:0] rb, input string tag);
    op(psw, ra, rb, 1'b0, 3'd0, 16'h0, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 16'h0, tag);
  endtask

  task automatic wr(input logic [15:0] psw, input logic [2:0] ws, input logic [15:0] wd);
    op(psw, 3'd0, 3'd7, 1'b1, ws, wd, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 16'h0, "");
  endtask

  function automatic logic [15:0] mk_psw(input logic [1:0] md, input logic bk);
    logic [15:0] p;
    p = 16'h0;
    p[15:14] = md;
    p[11] = bk;
    return p;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] md;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    psw_i = '0; rd_a_sel_i = '0; rd_b_sel_i = '0; wr_en_i = 0; wr_sel_i = '0; wr_data_i = '0;
    sp_wr_en_i = 0; sp_wr_mode_i = '0; sp_wr_data_i = '0; pc_inc_i = 0; pc_load_i = 0; pc_load_data_i = '0;
    for (int i = 0; i < 16; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "in reset", rd_a_data_o, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: all numbers, both banks, all modes read zero
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 8; s++)
        rd(mk_psw(2'(p >> 1), p[0]), 3'(s), 3'(7 - s), "R1");

    // R2 and R3: distinct values everywhere via the write port
    for (int s = 0; s < 6; s++) begin
      wr(mk_psw(2'b00, 1'b0), 3'(s), 16'h1000 + 16'(s));
      wr(mk_psw(2'b11, 1'b1), 3'(s), 16'h2000 + 16'(s));
    end
    wr(mk_psw(2'b00, 1'b0), 3'd6, 16'hA000);
    wr(mk_psw(2'b01, 1'b1), 3'd6, 16'hB000);
    wr(mk_psw(2'b11, 1'b0), 3'd6, 16'hC000);
    for (int s = 0; s < 6; s++) begin
      rd(mk_psw(2'b01, 1'b0), 3'(s), 3'(s), "R2");
      rd(mk_psw(2'b10, 1'b1), 3'(s), 3'(5 - s), "R2");
    end
    for (int p = 0; p < 4; p++) rd(mk_psw(2'(p), 1'b0), 3'd6, 3'd6, "R3");
    rd(mk_psw(2'b10, 1'b1), 3'd6, 3'd1, "R3");  // reserved mode reaches kernel pointer
    chk("R3", "reserved mode sp", m[12], 16'hA000);

    // R5: different numbers on the two ports at once
    rd(mk_psw(2'b00, 1'b1), 3'd2, 3'd6, "R5");
    rd(mk_psw(2'b11, 1'b0), 3'd7, 3'd4, "R5");

    // R4 and R11: PC through write port, with load and inc contending
    op(mk_psw(2'b01, 1'b1), 3'd7, 3'd7, 1'b1, 3'd7, 16'h4444, 1'b0, 2'b00, 16'h0, 1'b1, 1'b1, 16'h5555, "R6");
    rd(mk_psw(2'b11, 1'b0), 3'd7, 3'd7, "R11");
    rd(mk_psw(2'b00, 1'b1), 3'd7, 3'd0, "R4");

    // R10: load beats increment
    op(mk_psw(2'b00, 1'b0), 3'd0, 3'd1, 1'b0, 3'd0, 16'h0, 1'b0, 2'b00, 16'h0, 1'b1, 1'b1, 16'h1230, "");
    rd(mk_psw(2'b00, 1'b0), 3'd7, 3'd7, "R10");

    // R9: increment and wrap
    op(mk_psw(2'b00, 1'b0), 3'd0, 3'd1, 1'b0, 3'd0, 16'h0, 1'b0, 2'b00, 16'h0, 1'b1, 1'b0, 16'h0, "");
    rd(mk_psw(2'b00, 1'b0), 3'd7, 3'd7, "R9");
    op(mk_psw(2'b00, 1'b0), 3'd0, 3'd1, 1'b0, 3'd0, 16'h0, 1'b0, 2'b00, 16'h0, 1'b0, 1'b1, 16'hFFFE, "");
    op(mk_psw(2'b00, 1'b0), 3'd0, 3'd1, 1'b0, 3'd0, 16'h0, 1'b0, 2'b00, 16'h0, 1'b1, 1'b0, 16'h0, "");
    rd(mk_psw(2'b00, 1'b0), 3'd7, 3'd7, "R9");
    chk("R9", "wrap model", m[15], 16'h0000);

    // R7: side port writes supervisor and reserved-as-kernel while in user mode
    op(mk_psw(2'b11, 1'b0), 3'd6, 3'd0, 1'b0, 3'd0, 16'h0, 1'b1, 2'b01, 16'h5A5A, 1'b0, 1'b0, 16'h0, "");
    rd(mk_psw(2'b01, 1'b0), 3'd6, 3'd6, "R7");
    rd(mk_psw(2'b11, 1'b0), 3'd6, 3'd6, "R7");
    op(mk_psw(2'b11, 1'b0), 3'd6, 3'd0, 1'b0, 3'd0, 16'h0, 1'b1, 2'b10, 16'h6B6B, 1'b0, 1'b0, 16'h0, "");
    rd(mk_psw(2'b00, 1'b0), 3'd6, 3'd6, "R7");

    // R8: both ports on the kernel pointer; write port wins
    op(mk_psw(2'b00, 1'b1), 3'd6, 3'd6, 1'b1, 3'd6, 16'h7777, 1'b1, 2'b00, 16'h8888, 1'b0, 1'b0, 16'h0, "R6");
    rd(mk_psw(2'b00, 1'b0), 3'd6, 3'd6, "R8");

    // R12: disabled write with live address and data
    op(mk_psw(2'b00, 1'b0), 3'd3, 3'd6, 1'b0, 3'd3, 16'hDEAD, 1'b0, 2'b00, 16'hBEEF, 1'b0, 1'b0, 16'h0, "");
    rd(mk_psw(2'b00, 1'b0), 3'd3, 3'd6, "R12");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      md = 2'($urandom_range(0, 3));
      op(mk_psw(md, 1'($urandom_range(0, 1))) | (16'($urandom) & 16'h37FF),
         3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
         1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 16'($urandom),
         ($urandom_range(0, 4) == 0), 2'($urandom_range(0, 3)), 16'($urandom),
         ($urandom_range(0, 2) == 0), ($urandom_range(0, 9) == 0), 16'($urandom), "");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule